// File: doc/BRIEF.md
# Serial Mouse Responder

This block is the device end of a pointing peripheral on a three-wire serial game port. The host controls a latch line and a clock line, and the device answers on one data line that is active-low. Motion arrives as signed X/Y delta beats on a valid/ready stream. The block adds the beats into one saturating accumulator per axis and keeps the two button levels as they arrive.

A rising edge on the latch takes a snapshot of three things into a 32-bit frame: the buttons, the current sensitivity setting and the accumulated motion. The same snapshot clears the accumulators. After the latch ends, each rising edge of the host clock moves the next frame bit onto the line.

The block also counts runs of short latch pulses that each carry a host clock pulse. A complete run steps the sensitivity setting to the next value. Latch and clock pass through two-flop synchronizers before any logic uses them.

Stream rules: `motion_ready` is low during reset and high at all other times, so the stream has no back-pressure. A beat is accepted in each cycle where `motion_valid` and `motion_ready` are both high. A beat accepted in the same cycle as a snapshot is counted toward the following frame.

Top module: `mouse_responder`

## Requirements
- R1: During and after reset, with no latch seen, `data_n` is high and `sens_mode` is 2'b00 (low sensitivity). `motion_ready` is high once reset is released.
- R2: A latch rising edge loads the frame, and frame bit 1 is then on the line. Each host clock rising edge with the latch low moves the line to the next bit. From bit 33 onward the line is high.
- R3: The line is the inverse of the logical bit: a logical 1 drives `data_n` low.
- R4: Logical bit 9 carries the left button and bit 10 carries the right button. Bit 16 is always logical 1. Bits 1 to 8 and 13 to 15 are logical 0.
- R5: Bits 11 and 12 report the sensitivity as logical (1,0) for high, (0,1) for medium and (0,0) for low.
- R6: Bit 17 is the Y direction and bits 18 to 24 are the Y magnitude, most significant bit first. Bit 25 is the X direction and bits 26 to 32 are the X magnitude, most significant bit first. The direction bit is 1 for a positive net sum: down for Y, right for X.
- R7: Each accepted beat adds its signed delta to that axis, and the sum is clamped to the range -127..+127 after every beat.
- R8: A snapshot clears both accumulators. Motion accepted after a latch edge appears in the next frame. A net sum of zero reports magnitude 0 and keeps the direction bit from the previous frame.
- R9: A run of STEP_PULSES (default 31) consecutive latch pulses moves the sensitivity one step (low → medium → high → low). Each pulse must last at most SHORT_MAX cycles and contain a host clock falling edge. The `sens_mode` encoding is 00 low, 01 medium, 10 high.
- R10: A latch pulse that lasts too long, or that contains no clock falling edge, starts the run count again from zero. The sensitivity does not change.
- R11: Host clock pulses while the latch is high do not advance the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_in | input | 1 | Host latch line, asynchronous |
| sclk_in | input | 1 | Host clock line, idle high, asynchronous |
| motion_valid | input | 1 | Motion beat valid |
| motion_ready | output | 1 | Motion beat accepted when high |
| dx_in | input | DELTA_W | Signed X delta, positive is right |
| dy_in | input | DELTA_W | Signed Y delta, positive is down |
| btn_left | input | 1 | Left button, 1 = pressed |
| btn_right | input | 1 | Right button, 1 = pressed |
| data_n | output | 1 | Active-low serial data to host |
| sens_mode | output | 2 | Current sensitivity code |

## Verification
A table of motion and button patterns is read back as whole frames. The patterns are small values of mixed sign, pairs of beats that pass the clamp, a most-negative delta, and beats that cancel to zero. Together they separate errors in sign handling, saturation, bit order and direction persistence. Directed tests then inject a beat in the middle of a readout, which shows whether the snapshot boundary is in the right place. They pulse the host clock inside a latch to show that no shift takes place. They send complete and broken runs of short pulses, which separate correct counting of the run from early steps and from a count that is never restarted.

// File: rtl/mouse_pkg.sv
package mouse_pkg;
  localparam int FRAME_W = 32;
  localparam int MAG_W   = 7;

  typedef enum logic [1:0] {
    SENS_LOW  = 2'b00,
    SENS_MED  = 2'b01,
    SENS_HIGH = 2'b10
  } sens_e;

  function automatic sens_e sens_next(input sens_e cur);
    case (cur)
      SENS_LOW:  sens_next = SENS_MED;
      SENS_MED:  sens_next = SENS_HIGH;
      default:   sens_next = SENS_LOW;
    endcase
  endfunction
endpackage

// File: rtl/mr_sync.sv
module mr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mr_axis_acc.sv
module mr_axis_acc #(
  parameter int DW = 8,
  parameter int MW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat,
  input  logic signed [DW-1:0] delta,
  input  logic                 snap,
  output logic [MW-1:0]        mag,
  output logic                 dir,
  output logic [MW:0]          acc_o
);
  localparam int AW = MW + 1;
  localparam int SW = ((DW > AW) ? DW : AW) + 1;
  localparam logic signed [SW-1:0] POS_LIM = SW'((1 << MW) - 1);
  localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

  logic signed [AW-1:0] acc_q;
  logic                 dir_q;
  logic signed [SW-1:0] acc_ext, d_ext, base, sum;
  logic signed [AW-1:0] sum_sat, neg_acc;
  logic                 dir_now;

  always_comb begin
    acc_ext = {{(SW-AW){acc_q[AW-1]}}, acc_q};
    d_ext   = beat ? {{(SW-DW){delta[DW-1]}}, delta} : '0;
    base    = snap ? '0 : acc_ext;
    sum     = base + d_ext;
    if (sum > POS_LIM)      sum_sat = POS_LIM[AW-1:0];
    else if (sum < NEG_LIM) sum_sat = NEG_LIM[AW-1:0];
    else                    sum_sat = sum[AW-1:0];
    neg_acc = -acc_q;
    mag     = acc_q[AW-1] ? neg_acc[MW-1:0] : acc_q[MW-1:0];
    dir_now = (acc_q != '0) ? ~acc_q[AW-1] : dir_q;
    dir     = dir_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      dir_q <= 1'b0;
    end else begin
      acc_q <= sum_sat;
      if (snap) dir_q <= dir_now;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mr_step_detect.sv
module mr_step_detect
  import mouse_pkg::*;
#(
  parameter int SHORT_MAX   = 300,
  parameter int STEP_PULSES = 31
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lat_lvl,
  input  logic  lat_rise,
  input  logic  lat_fall,
  input  logic  clk_fall,
  output sens_e sens
);
  localparam int LW = $clog2(SHORT_MAX + 2);
  localparam int CW = $clog2(STEP_PULSES + 1);
  localparam logic [LW-1:0] LEN_CAP = LW'(SHORT_MAX + 1);
  localparam logic [LW-1:0] LEN_OK  = LW'(SHORT_MAX);
  localparam logic [CW-1:0] CNT_END = CW'(STEP_PULSES - 1);

  logic [LW-1:0] len_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;
  sens_e         sens_q;
  logic          pulse_ok;

  assign pulse_ok = seen_q && (len_q <= LEN_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      sens_q <= SENS_LOW;
    end else begin
      if (lat_rise) begin
        len_q  <= '0;
        seen_q <= 1'b0;
      end else if (lat_lvl) begin
        if (len_q != LEN_CAP) len_q <= len_q + 1'b1;
        if (clk_fall)         seen_q <= 1'b1;
      end
      if (lat_fall) begin
        if (pulse_ok) begin
          if (cnt_q == CNT_END) begin
            cnt_q  <= '0;
            sens_q <= sens_next(sens_q);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign sens = sens_q;
endmodule

// File: rtl/mr_shifter.sv
module mr_shifter #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          shift,
  output logic          line_n
);
  logic [FW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= frame;
    else if (shift) sr_q <= {sr_q[FW-2:0], 1'b0};
  end

  assign line_n = ~sr_q[FW-1];
endmodule

// File: rtl/mouse_responder.sv
module mouse_responder
  import mouse_pkg::*;
#(
  parameter int DELTA_W     = 8,
  parameter int SHORT_MAX   = 300,
  parameter int STEP_PULSES = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_in,
  input  logic               sclk_in,
  input  logic               motion_valid,
  output logic               motion_ready,
  input  logic [DELTA_W-1:0] dx_in,
  input  logic [DELTA_W-1:0] dy_in,
  input  logic               btn_left,
  input  logic               btn_right,
  output logic               data_n,
  output logic [1:0]         sens_mode
);
  localparam int P_LEFT  = FRAME_W - 9;
  localparam int P_RIGHT = FRAME_W - 10;
  localparam int P_SHI   = FRAME_W - 11;
  localparam int P_SMED  = FRAME_W - 12;
  localparam int P_ID    = FRAME_W - 16;
  localparam int P_YDIR  = FRAME_W - 17;
  localparam int P_YMAG  = FRAME_W - 18;
  localparam int P_XDIR  = FRAME_W - 25;
  localparam int P_XMAG  = FRAME_W - 26;

  logic [1:0] sync_w;
  logic       lat_s, sck_s, lat_d, sck_d;
  logic       lat_rise, lat_fall, sck_fall, sck_rise, shift_en;
  logic       ready_q, beat;
  logic [MAG_W-1:0] x_mag, y_mag;
  logic             x_dir, y_dir;
  logic [MAG_W:0]   acc_x, acc_y;
  logic [FRAME_W-1:0] frame;
  sens_e sens;

  mr_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({latch_in, sclk_in}),
    .sync_out(sync_w)
  );
  assign lat_s = sync_w[1];
  assign sck_s = sync_w[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_d   <= 1'b0;
      sck_d   <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      lat_d   <= lat_s;
      sck_d   <= sck_s;
      ready_q <= 1'b1;
    end
  end

  assign lat_rise = lat_s & ~lat_d;
  assign lat_fall = ~lat_s & lat_d;
  assign sck_fall = ~sck_s & sck_d;
  assign sck_rise = sck_s & ~sck_d;
  assign shift_en = sck_rise & ~lat_s & ~lat_d;

  assign motion_ready = ready_q;
  assign beat = motion_valid & ready_q;

  mr_axis_acc #(.DW(DELTA_W), .MW(MAG_W)) u_acc_x (
    .clk(clk), .rst_n(rst_n), .beat(beat), .delta(dx_in), .snap(lat_rise),
    .mag(x_mag), .dir(x_dir), .acc_o(acc_x)
  );

  mr_axis_acc #(.DW(DELTA_W), .MW(MAG_W)) u_acc_y (
    .clk(clk), .rst_n(rst_n), .beat(beat), .delta(dy_in), .snap(lat_rise),
    .mag(y_mag), .dir(y_dir), .acc_o(acc_y)
  );

  mr_step_detect #(.SHORT_MAX(SHORT_MAX), .STEP_PULSES(STEP_PULSES)) u_step (
    .clk(clk), .rst_n(rst_n), .lat_lvl(lat_s), .lat_rise(lat_rise),
    .lat_fall(lat_fall), .clk_fall(sck_fall), .sens(sens)
  );

  always_comb begin
    frame = '0;
    frame[P_LEFT]  = btn_left;
    frame[P_RIGHT] = btn_right;
    frame[P_SHI]   = (sens == SENS_HIGH);
    frame[P_SMED]  = (sens == SENS_MED);
    frame[P_ID]    = 1'b1;
    frame[P_YDIR]  = y_dir;
    frame[P_YMAG -: MAG_W] = y_mag;
    frame[P_XDIR]  = x_dir;
    frame[P_XMAG -: MAG_W] = x_mag;
  end

  mr_shifter #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(lat_rise), .frame(frame),
    .shift(shift_en), .line_n(data_n)
  );

  assign sens_mode = sens;
endmodule

// File: rtl/mouse_responder_chk.sv
module mr_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sens,
  input logic          data_n,
  input logic          lat_fall,
  input logic          load,
  input logic          shift,
  input logic [AW-1:0] acc_x,
  input logic [AW-1:0] acc_y
);
  localparam logic [AW-1:0] MOST_NEG = {1'b1, {(AW-1){1'b0}}};

  function automatic logic [1:0] step_of(input logic [1:0] s);
    step_of = (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b10 : 2'b00;
  endfunction

  // R9
  sens_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sens != 2'b11);

  // R9
  sens_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sens) |-> sens == step_of($past(sens)));

  // R10
  sens_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sens) |-> $past(lat_fall));

  // R7
  acc_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_x != MOST_NEG) && (acc_y != MOST_NEG));

  // R11
  line_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_n) |-> $past(load || shift));
endmodule

bind mouse_responder mr_chk #(.AW(mouse_pkg::MAG_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .sens(sens_mode), .data_n(data_n),
  .lat_fall(lat_fall), .load(lat_rise), .shift(shift_en),
  .acc_x(acc_x), .acc_y(acc_y)
);

// File: tb/mouse_responder_tb.sv
module mouse_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_in = 1'b0, sclk_in = 1'b1, motion_valid = 1'b0;
  logic [7:0] dx_in = '0, dy_in = '0;
  logic btn_left = 1'b0, btn_right = 1'b0;
  logic motion_ready, data_n;
  logic [1:0] sens_mode;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mouse_responder dut_i (
    .clk(clk), .rst_n(rst_n), .latch_in(latch_in), .sclk_in(sclk_in),
    .motion_valid(motion_valid), .motion_ready(motion_ready),
    .dx_in(dx_in), .dy_in(dy_in), .btn_left(btn_left), .btn_right(btn_right),
    .data_n(data_n), .sens_mode(sens_mode)
  );

  // {dx_a, dy_a, dx_b, dy_b, left, right, expected logical frame}
  localparam logic [65:0] VECS [6] = '{
    {8'h05, 8'hFD, 8'h00, 8'h00, 1'b1, 1'b0, 32'h00810385},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 32'h00410080},
    {8'h64, 8'h5A, 8'h64, 8'h5A, 1'b1, 1'b1, 32'h00C1FFFF},
    {8'h80, 8'hEC, 8'h0A, 8'hFB, 1'b0, 1'b0, 32'h00011975},
    {8'hF9, 8'h07, 8'h07, 8'hF9, 1'b0, 1'b0, 32'h00010000},
    {8'hCE, 8'h3C, 8'h9C, 8'h00, 1'b0, 1'b1, 32'h0041BC7F}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_beat(input logic [7:0] dx, input logic [7:0] dy);
    motion_valid = 1'b1; dx_in = dx; dy_in = dy;
    wait_n(1);
    motion_valid = 1'b0; dx_in = '0; dy_in = '0;
    wait_n(1);
  endtask

  task automatic clock_pulse();
    sclk_in = 1'b0; wait_n(4);
    sclk_in = 1'b1; wait_n(6);
  endtask

  task automatic do_latch(input int high_cycles, input int inner_clocks);
    latch_in = 1'b1; wait_n(4);
    for (int c = 0; c < inner_clocks; c++) clock_pulse();
    wait_n(high_cycles);
    latch_in = 1'b0; wait_n(8);
  endtask

  task automatic shift_bits(input int inject_at, output logic [31:0] f);
    for (int k = 0; k < 32; k++) begin
      if (k == inject_at) push_beat(8'h03, 8'h04);
      f[31-k] = ~data_n;
      clock_pulse();
    end
  endtask

  task automatic read_frame(input int inject_at, output logic [31:0] f);
    do_latch(12, 0);
    shift_bits(inject_at, f);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] f;
    wait_n(5);
    // R1: reset state
    check(data_n === 1'b1, "R1 line idle in reset", {31'd0, data_n}, 32'd1);
    check(sens_mode === 2'b00, "R1 sens in reset", {30'd0, sens_mode}, 32'd0);
    rst_n = 1'b1;
    wait_n(3);
    check(motion_ready === 1'b1, "R1 ready after reset", {31'd0, motion_ready}, 32'd1);
    check(data_n === 1'b1, "R1 line idle after reset", {31'd0, data_n}, 32'd1);

    // R3 R4 R5 R6 R7 R8: table of motion/button patterns
    for (int v = 0; v < 6; v++) begin
      logic [65:0] e;
      e = VECS[v];
      push_beat(e[65:58], e[57:50]);
      push_beat(e[49:42], e[41:34]);
      btn_left = e[33]; btn_right = e[32];
      read_frame(-1, f);
      check(f === e[31:0], $sformatf("R6 R7 frame vector %0d", v), f, e[31:0]);
      // R2: bit 33 and beyond read high
      check(data_n === 1'b1, "R2 line after bit 32", {31'd0, data_n}, 32'd1);
    end
    btn_left = 1'b0; btn_right = 1'b0;

    // R2: extra clocks stay high
    clock_pulse(); clock_pulse();
    check(data_n === 1'b1, "R2 extra clocks", {31'd0, data_n}, 32'd1);

    // R8: beat during readout lands in the next frame
    read_frame(5, f);
    check(f === 32'h00018000, "R8 mid-read beat excluded", f, 32'h00018000);
    read_frame(-1, f);
    check(f === 32'h00018483, "R8 mid-read beat next frame", f, 32'h00018483);

    // R11: clocks inside the latch do not shift
    push_beat(8'h02, 8'h00);
    do_latch(6, 3);
    shift_bits(-1, f);
    check(f === 32'h00018082, "R11 clocks in latch", f, 32'h00018082);

    // R9: complete runs step the sensitivity
    for (int p = 0; p < 31; p++) do_latch(6, 1);
    check(sens_mode === 2'b01, "R9 step to medium", {30'd0, sens_mode}, 32'd1);
    read_frame(-1, f);
    check(f === 32'h00118080, "R5 medium in frame", f, 32'h00118080);
    for (int p = 0; p < 31; p++) do_latch(6, 1);
    check(sens_mode === 2'b10, "R9 step to high", {30'd0, sens_mode}, 32'd2);
    read_frame(-1, f);
    check(f === 32'h00218080, "R5 high in frame", f, 32'h00218080);
    for (int p = 0; p < 31; p++) do_latch(6, 1);
    check(sens_mode === 2'b00, "R9 wrap to low", {30'd0, sens_mode}, 32'd0);

    // R10: broken runs
    for (int p = 0; p < 30; p++) do_latch(6, 1);
    do_latch(6, 0);
    do_latch(6, 1);
    check(sens_mode === 2'b00, "R10 pulse without clock", {30'd0, sens_mode}, 32'd0);
    for (int p = 0; p < 29; p++) do_latch(6, 1);
    do_latch(400, 1);
    do_latch(6, 1);
    check(sens_mode === 2'b00, "R10 long pulse", {30'd0, sens_mode}, 32'd0);
    for (int p = 0; p < 30; p++) do_latch(6, 1);
    check(sens_mode === 2'b01, "R10 run restarted counts to 31", {30'd0, sens_mode}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule